// File: doc/BRIEF.md
# Direct-Addressed Data Space with Move Engine

This block is the on-chip data space of a small 8-bit controller core. It holds 128 bytes of general-purpose RAM and a sparse set of special-function registers (accumulator, B, stack pointer, data pointer bytes, status word, interrupt enable and priority, power control, timer control, mode and count bytes, serial control and buffer, and four port latches). It executes one data-move command per clock. Each move uses one of three operand styles: an 8-bit direct address, an immediate byte, or a working-register index that is translated through the active register bank.

A command is presented on a valid/ready stream. `cmd_ready` rises on the first clock edge after reset and then stays high, so the block never back-pressures. A command is accepted on every rising edge where `cmd_valid` and `cmd_ready` are both high, and back-to-back commands are allowed. The result returns one cycle later on `done`, `err` and `mv_data`. These are single-cycle outputs with no ready of their own, and the consumer must sample them in that cycle. Port pins feed reads of the port addresses, and the port latches drive `port_latch`.

Top module: `dspace_mover`

## Requirements
- R1: Reset state. The stack pointer (81h) reads 07h. All four port latches are FFh. Every other special-function register, including the status word and therefore the bank-select bits, reads 00h. Every RAM byte reads 00h.
- R2: Direct addresses 00h–7Fh read and write the matching RAM byte.
- R3: The implemented upper addresses are 80h, 81h, 82h, 83h, 87h, 88h, 89h, 8Ah, 8Bh, 8Ch, 8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h (accumulator) and F0h. Each holds its own byte.
- R4: A move that reads or writes an upper address outside the R3 list returns `err`=1 and `mv_data`=00h, and it changes no state.
- R5: Working register r (command field `cmd_reg`, 0–7) maps to RAM address 8·bank + r. The bank is status-word (D0h) bit 4 (high) and bit 3 (low). A status-word write takes effect for the next accepted command.
- R6: `cmd_op` encodings: 0 moves direct src→A; 1 moves A→direct dst; 2 moves direct src→Rr; 3 moves Rr→direct dst; 4 moves the immediate byte→direct dst; 5 moves direct src→direct dst. `mv_data` reports the byte written.
- R7: Reading a port address (80h, 90h, A0h, B0h) returns the pins: P0 on `port_pins[7:0]`, P1 on [15:8], P2 on [23:16], P3 on [31:24]. Writing a port address updates only its latch, which appears at the same bit positions of `port_latch`.
- R8: A direct-to-direct move whose source equals its destination returns `err`=1 and leaves every byte unchanged.
- R9: Each accepted command writes its destination on the accepting edge and pulses `done` for exactly one cycle after it. `done` stays low in cycles without an accepted command, and `cmd_ready` is high from the first edge after reset.
- R10: Op codes 6 and 7 are undefined. They return `err`=1 and change no state.
- R11: A move into the accumulator or the status word updates that register like any other register write, and later moves read the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Move type (R6) |
| cmd_dst | input | 8 | Destination direct address |
| cmd_src | input | 8 | Source direct address |
| cmd_imm | input | 8 | Immediate byte |
| cmd_reg | input | 3 | Working-register index |
| port_pins | input | 32 | External pin levels of four ports |
| port_latch | output | 32 | Port output latches |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Completed command was rejected |
| mv_data | output | 8 | Byte moved by the completed command |

## Verification
The hardest case to reach is a register-mode access right after the bank bits change. Showing it requires a write to the status word followed immediately by a register move, and then a direct read of the translated RAM address. The stimulus does this directly, and it also mixes random status-word writes into a long random command stream that draws addresses from RAM, the implemented map and the unimplemented gaps. A behavioural model follows every cycle, so bank switches, port reads against changing pins, and same-address moves are all compared when they occur.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
  localparam int NSFR    = 21;
  localparam int SFR_IW  = $clog2(NSFR);
  localparam int NPORT   = 4;

  localparam logic [2:0] OP_DIR2A   = 3'd0;
  localparam logic [2:0] OP_A2DIR   = 3'd1;
  localparam logic [2:0] OP_DIR2R   = 3'd2;
  localparam logic [2:0] OP_R2DIR   = 3'd3;
  localparam logic [2:0] OP_IMM2DIR = 3'd4;
  localparam logic [2:0] OP_DIR2DIR = 3'd5;

  // register file slots: ports occupy the low slots so pin reads index them directly
  localparam int IDX_SP  = 4;
  localparam int IDX_PSW = 18;
  localparam int IDX_ACC = 19;

  function automatic logic [7:0] sfr_addr(input int unsigned i);
    case (i)
      0:  sfr_addr = 8'h80;  1:  sfr_addr = 8'h90;
      2:  sfr_addr = 8'hA0;  3:  sfr_addr = 8'hB0;
      4:  sfr_addr = 8'h81;  5:  sfr_addr = 8'h82;
      6:  sfr_addr = 8'h83;  7:  sfr_addr = 8'h87;
      8:  sfr_addr = 8'h88;  9:  sfr_addr = 8'h89;
      10: sfr_addr = 8'h8A;  11: sfr_addr = 8'h8B;
      12: sfr_addr = 8'h8C;  13: sfr_addr = 8'h8D;
      14: sfr_addr = 8'h98;  15: sfr_addr = 8'h99;
      16: sfr_addr = 8'hA8;  17: sfr_addr = 8'hB8;
      18: sfr_addr = 8'hD0;  19: sfr_addr = 8'hE0;
      20: sfr_addr = 8'hF0;
      default: sfr_addr = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] sfr_rst(input int unsigned i);
    if (i < NPORT)        sfr_rst = 8'hFF;
    else if (i == IDX_SP) sfr_rst = 8'h07;
    else                  sfr_rst = 8'h00;
  endfunction
endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
  import dspace_pkg::*;
(
  input  logic [7:0]        addr,
  output logic              is_ram,
  output logic              hit,
  output logic [SFR_IW-1:0] idx
);
  logic [NSFR-1:0] match;

  for (genvar g = 0; g < NSFR; g++) begin : g_cmp
    assign match[g] = (addr == sfr_addr(g));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSFR; i++)
      if (match[i]) idx = SFR_IW'(i);
  end

  assign hit    = |match;
  assign is_ram = ~addr[7];

  // R3: no two register slots share an address
  always_comb begin
    p_unique_map_r3: assert ($onehot0(match));
  end
endmodule

// File: rtl/dspace_ram.sv
module dspace_ram #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dspace_sfr.sv
module dspace_sfr
  import dspace_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SFR_IW-1:0]  widx,
  input  logic [7:0]         wdata,
  input  logic [SFR_IW-1:0]  ridx,
  input  logic [NPORT*8-1:0] pins,
  output logic [7:0]         rdata,
  output logic [7:0]         acc,
  output logic [1:0]         bank,
  output logic [NPORT*8-1:0] latches
);
  logic [7:0] regs [NSFR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSFR; i++) regs[i] <= sfr_rst(i);
    end else if (we) begin
      regs[widx] <= wdata;
    end
  end

  // ports read the pins, every other slot reads its register
  always_comb begin
    if (int'(ridx) < NPORT) rdata = pins[int'(ridx)*8 +: 8];
    else                    rdata = regs[ridx];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_latch
    assign latches[p*8 +: 8] = regs[p];
  end

  assign acc  = regs[IDX_ACC];
  assign bank = regs[IDX_PSW][4:3];

  // R1: stack pointer holds 07h while reset is applied
  p_sp_reset_r1: assert property (@(posedge clk) !rst_n |=> regs[IDX_SP] == 8'h07);
endmodule

// File: rtl/dspace_mover.sv
module dspace_mover
  import dspace_pkg::*;
#(
  parameter int RAM_DEPTH = 128,
  localparam int AW       = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [7:0]         cmd_dst,
  input  logic [7:0]         cmd_src,
  input  logic [7:0]         cmd_imm,
  input  logic [2:0]         cmd_reg,
  input  logic [NPORT*8-1:0] port_pins,
  output logic [NPORT*8-1:0] port_latch,
  output logic               done,
  output logic               err,
  output logic [7:0]         mv_data
);
  logic              s_ram, s_hit, d_ram, d_hit;
  logic [SFR_IW-1:0] s_idx, d_idx;
  logic [1:0]        bank;
  logic [7:0]        acc, sfr_rdata, ram_rdata, dir_val, mv;
  logic [AW-1:0]     reg_addr, ram_raddr, ram_waddr;
  logic              op_ok, rd_dir, wr_dir, to_acc, to_reg;
  logic              err_c, fire, wen, ram_we, sfr_we;
  logic [SFR_IW-1:0] sfr_widx;
  logic              ready_q, done_q, err_q;
  logic [7:0]        mv_q;

  dspace_decode u_sdec (.addr(cmd_src), .is_ram(s_ram), .hit(s_hit), .idx(s_idx));
  dspace_decode u_ddec (.addr(cmd_dst), .is_ram(d_ram), .hit(d_hit), .idx(d_idx));

  // working register r of the active bank lives at 8*bank + r
  assign reg_addr  = AW'({bank, cmd_reg});
  assign ram_raddr = (cmd_op == OP_R2DIR) ? reg_addr : cmd_src[AW-1:0];
  assign dir_val   = s_ram ? ram_rdata : sfr_rdata;

  always_comb begin
    op_ok  = 1'b1;
    rd_dir = 1'b0;
    wr_dir = 1'b0;
    to_acc = 1'b0;
    to_reg = 1'b0;
    mv     = 8'h00;
    case (cmd_op)
      OP_DIR2A:   begin rd_dir = 1'b1; to_acc = 1'b1; mv = dir_val; end
      OP_A2DIR:   begin wr_dir = 1'b1; mv = acc; end
      OP_DIR2R:   begin rd_dir = 1'b1; to_reg = 1'b1; mv = dir_val; end
      OP_R2DIR:   begin wr_dir = 1'b1; mv = ram_rdata; end
      OP_IMM2DIR: begin wr_dir = 1'b1; mv = cmd_imm; end
      OP_DIR2DIR: begin rd_dir = 1'b1; wr_dir = 1'b1; mv = dir_val; end
      default:    op_ok = 1'b0;
    endcase
  end

  assign err_c = !op_ok
               | (rd_dir & !s_ram & !s_hit)
               | (wr_dir & !d_ram & !d_hit)
               | ((cmd_op == OP_DIR2DIR) & (cmd_src == cmd_dst));

  assign fire      = cmd_valid & cmd_ready;
  assign wen       = fire & !err_c;
  assign ram_we    = wen & ((wr_dir & d_ram) | to_reg);
  assign ram_waddr = to_reg ? reg_addr : cmd_dst[AW-1:0];
  assign sfr_we    = wen & ((wr_dir & !d_ram) | to_acc);
  assign sfr_widx  = to_acc ? SFR_IW'(IDX_ACC) : d_idx;

  dspace_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(mv),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  dspace_sfr u_sfr (
    .clk(clk), .rst_n(rst_n), .we(sfr_we), .widx(sfr_widx), .wdata(mv),
    .ridx(s_idx), .pins(port_pins), .rdata(sfr_rdata), .acc(acc), .bank(bank),
    .latches(port_latch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      mv_q    <= 8'h00;
    end else begin
      ready_q <= 1'b1;
      done_q  <= fire;
      err_q   <= fire & err_c;
      mv_q    <= (fire && !err_c) ? mv : 8'h00;
    end
  end

  assign cmd_ready = ready_q;
  assign done      = done_q;
  assign err       = err_q;
  assign mv_data   = mv_q;

  // R9: a completion strobe only follows an accepted command
  p_done_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready));
  // R4: a rejected command leaves the port latches alone
  p_err_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(port_latch));
  // R10: a rejected command leaves the accumulator alone
  p_err_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(acc));
  // R8: same-address direct move is always rejected
  p_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_DIR2DIR && cmd_src == cmd_dst) |=> err && done);
endmodule

// File: tb/dspace_mover_test.sv
`timescale 1ns/1ps
module dspace_mover_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_dst = '0, cmd_src = '0, cmd_imm = '0;
  logic [2:0]  cmd_reg = '0;
  logic [31:0] port_pins = 32'h0;
  logic [31:0] port_latch;
  logic        done, err;
  logic [7:0]  mv_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] m_ram [128];
  logic [7:0] m_sfr [256];
  logic       last_err;
  logic [7:0] last_mv;

  always #2 clk = ~clk;

  dspace_mover uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_imm(cmd_imm),
    .cmd_reg(cmd_reg), .port_pins(port_pins), .port_latch(port_latch),
    .done(done), .err(err), .mv_data(mv_data)
  );

  localparam logic [7:0] MAP [21] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89,
    8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8, 8'hB0, 8'hB8,
    8'hD0, 8'hE0, 8'hF0};

  function automatic bit implemented(input logic [7:0] a);
    foreach (MAP[i]) if (MAP[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a < 8'h80) return m_ram[a[6:0]];
    case (a)
      8'h80: return port_pins[7:0];
      8'h90: return port_pins[15:8];
      8'hA0: return port_pins[23:16];
      8'hB0: return port_pins[31:24];
      default: return m_sfr[a];
    endcase
  endfunction

  function automatic void mwrite(input logic [7:0] a, input logic [7:0] v);
    if (a < 8'h80) m_ram[a[6:0]] = v;
    else m_sfr[a] = v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
    for (int i = 0; i < 256; i++) m_sfr[i] = 8'h00;
    m_sfr[8'h80] = 8'hFF; m_sfr[8'h90] = 8'hFF; m_sfr[8'hA0] = 8'hFF; m_sfr[8'hB0] = 8'hFF;
    m_sfr[8'h81] = 8'h07;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one command: returns error and moved byte, updates state
  task automatic model_step(input logic [2:0] op, input logic [7:0] d, input logic [7:0] s,
                            input logic [7:0] imm, input logic [2:0] r,
                            output logic e, output logic [7:0] v);
    logic [7:0] ra;
    ra = {1'b0, 2'b00, m_sfr[8'hD0][4:3], r} ;
    ra = {3'b000, m_sfr[8'hD0][4:3], r};
    e = 1'b0; v = 8'h00;
    case (op)
      3'd0: if (s >= 8'h80 && !implemented(s)) e = 1; else v = mread(s);
      3'd1: if (d >= 8'h80 && !implemented(d)) e = 1; else v = m_sfr[8'hE0];
      3'd2: if (s >= 8'h80 && !implemented(s)) e = 1; else v = mread(s);
      3'd3: if (d >= 8'h80 && !implemented(d)) e = 1; else v = m_ram[ra[6:0]];
      3'd4: if (d >= 8'h80 && !implemented(d)) e = 1; else v = imm;
      3'd5: if ((s >= 8'h80 && !implemented(s)) || (d >= 8'h80 && !implemented(d)) || s == d) e = 1;
            else v = mread(s);
      default: e = 1;
    endcase
    if (e) v = 8'h00;
    else case (op)
      3'd0: m_sfr[8'hE0] = v;
      3'd2: m_ram[ra[6:0]] = v;
      default: mwrite(d, v);
    endcase
  endtask

  function automatic logic [31:0] exp_latch();
    return {m_sfr[8'hB0], m_sfr[8'hA0], m_sfr[8'h90], m_sfr[8'h80]};
  endfunction

  // drive at a falling edge, accept on the rising edge, compare at the next falling edge
  task automatic issue(input string tag, input logic [2:0] op, input logic [7:0] d,
                       input logic [7:0] s, input logic [7:0] imm, input logic [2:0] r);
    logic e; logic [7:0] v;
    cmd_valid = 1'b1; cmd_op = op; cmd_dst = d; cmd_src = s; cmd_imm = imm; cmd_reg = r;
    model_step(op, d, s, imm, r, e, v);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({tag, " done"}, {31'b0, done}, 32'd1);
    check({tag, " err"}, {31'b0, err}, {31'b0, e});
    check({tag, " data"}, {24'b0, mv_data}, {24'b0, v});
    check({tag, " latch"}, port_latch, exp_latch());
    last_err = err; last_mv = mv_data;
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R9 idle done", {31'b0, done}, 32'd0);
    check("R9 idle latch", port_latch, exp_latch());
  endtask

  function automatic logic [7:0] pick_addr();
    int k;
    k = $urandom_range(0, 9);
    if (k < 2) return 8'($urandom_range(0, 31));
    if (k < 5) return 8'($urandom_range(0, 127));
    if (k < 9) return MAP[$urandom_range(0, 20)];
    return 8'($urandom_range(128, 255));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R9 ready
    check("R1 latch reset", port_latch, 32'hFFFF_FFFF);
    check("R9 ready", {31'b0, cmd_ready}, 32'd1);
    check("R9 no done", {31'b0, done}, 32'd0);
    issue("R1 sp", 3'd0, 8'h00, 8'h81, 8'h00, 3'd0);
    check("R1 sp value", {24'b0, last_mv}, 32'h07);
    issue("R1 psw", 3'd0, 8'h00, 8'hD0, 8'h00, 3'd0);
    check("R1 psw value", {24'b0, last_mv}, 32'h00);
    issue("R1 ram", 3'd0, 8'h00, 8'h55, 8'h00, 3'd0);
    // R2 RAM direct
    issue("R2 imm", 3'd4, 8'h3A, 8'h00, 8'h3A, 3'd0);
    issue("R2 read", 3'd0, 8'h00, 8'h3A, 8'h00, 3'd0);
    check("R2 value", {24'b0, last_mv}, 32'h3A);
    // R3 every register keeps its own byte
    foreach (MAP[i]) issue("R3 write", 3'd4, MAP[i], 8'h00, 8'(8'h40 + i), 3'd0);
    foreach (MAP[i]) if (MAP[i][3:0] != 0 || MAP[i] == 8'hD0 || MAP[i] == 8'hE0 || MAP[i] == 8'hF0 || MAP[i] == 8'h98 || MAP[i] == 8'hA8 || MAP[i] == 8'hB8 || MAP[i] == 8'h88)
      issue("R3 read", 3'd0, 8'h00, MAP[i], 8'h00, 3'd0);
    // R5 bank switch takes effect on the very next command
    issue("R5 psw bank2", 3'd4, 8'hD0, 8'h00, 8'h10, 3'd0);
    issue("R5 reg write", 3'd2, 8'h00, 8'h3A, 8'h00, 3'd2);
    issue("R5 readback", 3'd0, 8'h00, 8'h12, 8'h00, 3'd0);
    check("R5 bank2 r2", {24'b0, last_mv}, 32'h3A);
    issue("R5 psw bank1", 3'd4, 8'hD0, 8'h00, 8'h08, 3'd0);
    issue("R5 reg read", 3'd3, 8'h60, 8'h00, 8'h00, 3'd7);
    issue("R11 psw bank0", 3'd4, 8'hD0, 8'h00, 8'h00, 3'd0);
    // R7 ports: pins on read, latch on write
    port_pins = 32'hC3A5_5A3C;
    issue("R7 pin read", 3'd0, 8'h00, 8'h90, 8'h00, 3'd0);
    check("R7 p1 pins", {24'b0, last_mv}, 32'h5A);
    issue("R7 latch write", 3'd1, 8'hB0, 8'h00, 8'h00, 3'd0);
    check("R7 p3 latch", {24'b0, port_latch[31:24]}, 32'h5A);
    // R11 accumulator written by move, then used
    issue("R11 acc load", 3'd4, 8'hE0, 8'h00, 8'h9E, 3'd0);
    issue("R11 acc out", 3'd1, 8'h80, 8'h00, 8'h00, 3'd0);
    check("R11 p0 latch", {24'b0, port_latch[7:0]}, 32'h9E);
    // R4 gaps in the upper range
    issue("R4 write gap", 3'd4, 8'h85, 8'h00, 8'h11, 3'd0);
    check("R4 err", {31'b0, last_err}, 32'd1);
    issue("R4 read gap", 3'd0, 8'h00, 8'hC0, 8'h00, 3'd0);
    issue("R4 acc kept", 3'd0, 8'h00, 8'hE0, 8'h00, 3'd0);
    check("R4 acc value", {24'b0, last_mv}, 32'h9E);
    // R8 same address
    issue("R8 same", 3'd5, 8'h3A, 8'h3A, 8'h00, 3'd0);
    check("R8 err", {31'b0, last_err}, 32'd1);
    issue("R8 kept", 3'd0, 8'h00, 8'h3A, 8'h00, 3'd0);
    issue("R6 dir2dir", 3'd5, 8'h88, 8'h3A, 8'h00, 3'd0);
    // R10 undefined op
    issue("R10 op6", 3'd6, 8'h80, 8'h3A, 8'h00, 3'd0);
    issue("R10 op7", 3'd7, 8'h20, 8'h3A, 8'h00, 3'd0);
    idle();
    // R6 random stream with bank changes, gaps and pin changes
    for (int n = 0; n < 3000; n++) begin
      if ((n % 16) == 0) port_pins = $urandom;
      if ($urandom_range(0, 9) == 0) idle();
      else issue("R6 random", 3'($urandom_range(0, 7)), pick_addr(), pick_addr(),
                 8'($urandom), 3'($urandom_range(0, 7)));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule